// File: doc/BRIEF.md
# Supervisory Shutdown and Reset Sequencer

This block turns digital supervisor flags into two system control outputs. One is an active-low power-off line that tells downstream regulators to shut down. The other is a system reset line whose polarity software can choose. The inputs are:

- the comparator results for four monitored rails;
- a watchdog-failure flag with a mode select;
- an asynchronous manual-reset input;
- a power-up indication;
- a small register write port.

Each output is driven by a hold stage. The stage asserts one clock edge after any of its causes is seen. Once every cause has cleared, it holds the output for a programmable number of cycles before releasing it. The reset output is also forced whenever power-off is active. This means a reset that comes from shutdown is released on the same cycle as shutdown.

Software reaches the block through a single-cycle write strobe with an 8-bit address and 8-bit data. Through it, software can force a shutdown (if permitted), select the hold length and select the reset polarity. The registers cannot be read back.

Top module: `sup_out_ctrl`

## Requirements
- R1: While `rst_ni` is low, `pwr_off_no` is 0 and `sys_rst_o` is 0. After reset the registers read as follows: permission lock = 1, force = 0, hold select = 0, polarity = 0.
- R2: While `por_i` is 1, power-off and reset are both asserted. Both release with the normal hold timing after `por_i` falls.
- R3: `rail1_ov_i` or `rail1_uv_i` being 1 asserts power-off and reset after the next clock edge.
- R4: With `rail2_lvl_en_i` = 1, a rail-2 state bit controls shutdown, and a cleared bit asserts power-off.
  - The bit sets when `rail2_above_on_i` is 1.
  - The bit clears when `rail2_above_off_i` is 0.
  - Otherwise the bit keeps its value.
  - With `rail2_lvl_en_i` = 0, rail 2 has no effect.
- R5: `wdt_fail_i` always asserts reset. It asserts power-off only while `wdt_adv_i` is 1.
- R6: Address 0x16 bit 2 is the force bit and address 0x18 bit 4 is the lock bit. Force=1 asserts power-off only while lock=0. While lock=1 the force bit is ignored.
- R7: Hold length H is 4 << (2*sel), where sel is address 0x10 bits [1:0]; this gives 4, 16, 64 or 256 cycles. An output is released on the H-th clock edge that sees all of its causes clear. A cause that is seen on any edge before that restarts the hold.
- R8: `rail3_uv_i` or `rail4_uv_i` asserts reset after the next edge and leaves power-off untouched.
- R9: `mr_ni` low passes through a two-flop synchronizer. Reset asserts after the third edge and power-off is unaffected.
- R10: A reset that comes only from power-off releases in the same cycle as power-off.
- R11: Address 0x0D bit 1 sets the reset polarity: 0 = active low and 1 = active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-up in progress |
| rail1_ov_i | input | 1 | Rail 1 above its upper threshold |
| rail1_uv_i | input | 1 | Rail 1 below its lower threshold |
| rail2_lvl_en_i | input | 1 | Rail 2 level-sensitive supervision enable |
| rail2_above_on_i | input | 1 | Rail 2 above its turn-on threshold |
| rail2_above_off_i | input | 1 | Rail 2 above its turn-off threshold |
| rail3_uv_i | input | 1 | Rail 3 below threshold |
| rail4_uv_i | input | 1 | Rail 4 below threshold |
| wdt_fail_i | input | 1 | Watchdog failure |
| wdt_adv_i | input | 1 | Advanced watchdog mode (failure also shuts down) |
| mr_ni | input | 1 | Manual reset, active low, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| pwr_off_no | output | 1 | Power-off request, active low |
| sys_rst_o | output | 1 | System reset, polarity per R11 |

## Verification
The main collision is a cause returning on the exact clock edge on which the hold counter would otherwise expire. To provoke it, the bench clears a rail-1 fault, counts H-1 edges, and re-raises the fault just before edge H. It then requires both outputs to stay asserted and the full hold to start again. A second coincidence is power-off and reset releasing together. The bench judges it by sampling both pins after each edge of every shutdown release, and requiring them to drop on the same edge.

// File: rtl/sup_out_pkg.sv
package sup_out_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_FORCE = 8'h16;
  localparam logic [ADDR_W-1:0] ADDR_LOCK  = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_POL   = 8'h0D;
  localparam logic [ADDR_W-1:0] ADDR_HOLD  = 8'h10;

  localparam int unsigned BIT_FORCE = 2;
  localparam int unsigned BIT_LOCK  = 4;
  localparam int unsigned BIT_POL   = 1;

  typedef struct packed {
    logic       sw_lock;
    logic       sw_force;
    logic [1:0] hold_sel;
    logic       rst_pol;
  } sup_cfg_t;

  localparam sup_cfg_t CFG_RST = '{sw_lock: 1'b1, sw_force: 1'b0,
                                   hold_sel: 2'd0, rst_pol: 1'b0};
endpackage

// File: rtl/sup_reg_bank.sv
module sup_reg_bank
  import sup_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output sup_cfg_t          cfg_o
);
  sup_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_RST;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_FORCE: cfg_q.sw_force <= wdata_i[BIT_FORCE];
        ADDR_LOCK:  cfg_q.sw_lock  <= wdata_i[BIT_LOCK];
        ADDR_POL:   cfg_q.rst_pol  <= wdata_i[BIT_POL];
        ADDR_HOLD:  cfg_q.hold_sel <= wdata_i[1:0];
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  // R11
  pol_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_POL) |=> (cfg_q.rst_pol == $past(wdata_i[BIT_POL])));

  // R6
  lock_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_LOCK) |=> (cfg_q.sw_lock == $past(wdata_i[BIT_LOCK])));

  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_HOLD) |=> $stable(cfg_q.hold_sel));
endmodule

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sup_rail2_hyst.sv
module sup_rail2_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_on_i,
  input  logic above_off_i,
  output logic ok_o
);
  logic ok_q;

  // Set above the turn-on level, clear below the turn-off level, else keep.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ok_q <= 1'b0;
    else if (above_on_i)  ok_q <= 1'b1;
    else if (!above_off_i) ok_q <= 1'b0;
  end

  assign ok_o = ok_q;

  // R4
  hyst_keep_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_q && above_off_i) |=> ok_q);

  // R4
  hyst_keep_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_q && !above_on_i) |=> !ok_q);
endmodule

// File: rtl/sup_hold_stretch.sv
module sup_hold_stretch #(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned RST_CNT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cause_i,
  input  logic [CNT_W-1:0] hold_len_i,
  output logic             active_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= CNT_W'(RST_CNT);
    end else if (cause_i) begin
      active_q <= 1'b1;
      cnt_q    <= hold_len_i - 1'b1;
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign active_o = active_q;

  // R3
  cause_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> active_q);

  // R7
  no_spurious_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_q) |-> $past(cause_i));

  // R7
  no_early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> !$past(cause_i));
endmodule

// File: rtl/sup_out_ctrl.sv
module sup_out_ctrl
  import sup_out_pkg::*;
#(
  parameter int unsigned HOLD_BASE  = 4,
  parameter int unsigned HOLD_SHIFT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              rail1_ov_i,
  input  logic              rail1_uv_i,
  input  logic              rail2_lvl_en_i,
  input  logic              rail2_above_on_i,
  input  logic              rail2_above_off_i,
  input  logic              rail3_uv_i,
  input  logic              rail4_uv_i,
  input  logic              wdt_fail_i,
  input  logic              wdt_adv_i,
  input  logic              mr_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              pwr_off_no,
  output logic              sys_rst_o
);
  localparam int unsigned HOLD_MAX = HOLD_BASE << (3 * HOLD_SHIFT);
  localparam int unsigned CNT_W    = $clog2(HOLD_MAX + 1);
  localparam int unsigned N_STAGE  = 2;
  localparam int unsigned STG_SD   = 0;
  localparam int unsigned STG_RST  = 1;

  sup_cfg_t         cfg;
  logic             mr_sync_n;
  logic             mr_act;
  logic             rail2_ok;
  logic             sw_sd;
  logic [CNT_W-1:0] hold_len;
  logic [N_STAGE-1:0] stage_cause;
  logic [N_STAGE-1:0] stage_act;
  logic             sd_active;
  logic             rst_active;

  sup_reg_bank u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  sup_sync2 #(.RST_VAL(1'b1)) u_mr_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (mr_ni),
    .q_o    (mr_sync_n)
  );
  assign mr_act = ~mr_sync_n;

  sup_rail2_hyst u_rail2 (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .above_on_i  (rail2_above_on_i),
    .above_off_i (rail2_above_off_i),
    .ok_o        (rail2_ok)
  );

  assign sw_sd    = cfg.sw_force & ~cfg.sw_lock;
  assign hold_len = CNT_W'(HOLD_BASE) << (HOLD_SHIFT * cfg.hold_sel);

  assign stage_cause[STG_SD]  = por_i | rail1_ov_i | rail1_uv_i
                              | (rail2_lvl_en_i & ~rail2_ok)
                              | (wdt_fail_i & wdt_adv_i) | sw_sd;
  // Shutdown-driven reset is merged after the stages so both release together.
  assign stage_cause[STG_RST] = rail3_uv_i | rail4_uv_i | wdt_fail_i | mr_act;

  for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
    sup_hold_stretch #(
      .CNT_W   (CNT_W),
      .RST_CNT (HOLD_BASE - 1)
    ) u_hold (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cause_i    (stage_cause[g]),
      .hold_len_i (hold_len),
      .active_o   (stage_act[g])
    );
  end

  assign sd_active  = stage_act[STG_SD];
  assign rst_active = stage_act[STG_SD] | stage_act[STG_RST];

  assign pwr_off_no = ~sd_active;
  assign sys_rst_o  = cfg.rst_pol ? rst_active : ~rst_active;

  // R5
  wdt_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_fail_i |=> rst_active);

  // R6
  sw_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.sw_force && !cfg.sw_lock) |=> !pwr_off_no);

  // R8
  low_rail_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail3_uv_i || rail4_uv_i) |=> rst_active);

  // R9
  manual_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr_act |=> rst_active);

  // R2
  power_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (sd_active && rst_active));
endmodule

// File: tb/sim_sup_out_ctrl.sv
module sim_sup_out_ctrl;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       por_i = 1'b1;
  logic       rail1_ov_i = 1'b0, rail1_uv_i = 1'b0;
  logic       rail2_lvl_en_i = 1'b0, rail2_above_on_i = 1'b1, rail2_above_off_i = 1'b1;
  logic       rail3_uv_i = 1'b0, rail4_uv_i = 1'b0;
  logic       wdt_fail_i = 1'b0, wdt_adv_i = 1'b0;
  logic       mr_ni = 1'b1;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0;
  logic       pwr_off_no, sys_rst_o;

  int checks = 0;
  int errors = 0;
  logic pol = 1'b0;

  always #5 clk = ~clk;

  sup_out_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .por_i(por_i),
    .rail1_ov_i(rail1_ov_i), .rail1_uv_i(rail1_uv_i),
    .rail2_lvl_en_i(rail2_lvl_en_i), .rail2_above_on_i(rail2_above_on_i),
    .rail2_above_off_i(rail2_above_off_i),
    .rail3_uv_i(rail3_uv_i), .rail4_uv_i(rail4_uv_i),
    .wdt_fail_i(wdt_fail_i), .wdt_adv_i(wdt_adv_i), .mr_ni(mr_ni),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .pwr_off_no(pwr_off_no), .sys_rst_o(sys_rst_o)
  );

  function automatic logic sd_on();
    return pwr_off_no == 1'b0;
  endfunction

  function automatic logic rst_on();
    return sys_rst_o == pol;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0;
  endtask

  // Cause already cleared at a negedge; expect both pins to drop on edge h.
  task automatic release_both(input int h, input string req);
    for (int i = 1; i <= h; i++) begin
      step(1);
      chk(req, sd_on(), i < h);
      chk(req, rst_on(), i < h);
    end
  endtask

  task automatic release_rst(input int h, input string req);
    step(h - 1);
    chk(req, rst_on(), 1'b1);
    chk(req, sd_on(), 1'b0);
    step(1);
    chk(req, rst_on(), 1'b0);
  endtask

  task automatic t_reset_state();
    #1;
    chk("R1 pwr_off in reset", pwr_off_no, 1'b0);
    chk("R1 sys_rst in reset", sys_rst_o, 1'b0);
  endtask

  task automatic t_por();
    @(negedge clk);
    rst_ni = 1'b1;
    step(6);
    chk("R2 shutdown during power-up", sd_on(), 1'b1);
    chk("R2 reset during power-up", rst_on(), 1'b1);
    por_i = 1'b0;
    release_both(4, "R10 R2 power-up release");
  endtask

  task automatic t_rail1();
    rail1_ov_i = 1'b1;
    step(1);
    chk("R3 rail1 over shutdown", sd_on(), 1'b1);
    chk("R3 rail1 over reset", rst_on(), 1'b1);
    rail1_ov_i = 1'b0;
    release_both(4, "R3 R10 rail1 over release");
    rail1_uv_i = 1'b1;
    step(1);
    chk("R3 rail1 under shutdown", sd_on(), 1'b1);
    rail1_uv_i = 1'b0;
    release_both(4, "R3 rail1 under release");
  endtask

  task automatic t_rail2();
    rail2_lvl_en_i = 1'b1; rail2_above_on_i = 1'b0; rail2_above_off_i = 1'b0;
    step(2);
    chk("R4 rail2 low shuts down", sd_on(), 1'b1);
    rail2_above_off_i = 1'b1;
    step(3);
    chk("R4 rail2 rising between thresholds", sd_on(), 1'b1);
    rail2_above_on_i = 1'b1;
    step(4);
    chk("R4 rail2 hold after turn-on", sd_on(), 1'b1);
    step(1);
    chk("R4 rail2 released", sd_on(), 1'b0);
    rail2_above_on_i = 1'b0;
    step(3);
    chk("R4 rail2 falling between thresholds", sd_on(), 1'b0);
    rail2_above_off_i = 1'b0;
    step(1);
    chk("R4 rail2 state latency", sd_on(), 1'b0);
    step(1);
    chk("R4 rail2 below turn-off", sd_on(), 1'b1);
    rail2_above_on_i = 1'b1; rail2_above_off_i = 1'b1;
    step(5);
    chk("R4 rail2 recovered", sd_on(), 1'b0);
    rail2_above_on_i = 1'b0; rail2_above_off_i = 1'b0;
    rail2_lvl_en_i = 1'b0;
    step(3);
    chk("R4 rail2 disabled has no effect", sd_on(), 1'b0);
    rail2_above_on_i = 1'b1; rail2_above_off_i = 1'b1;
    step(1);
  endtask

  task automatic t_wdt();
    wdt_fail_i = 1'b1;
    step(1);
    chk("R5 basic watchdog reset", rst_on(), 1'b1);
    chk("R5 basic watchdog no shutdown", sd_on(), 1'b0);
    wdt_fail_i = 1'b0;
    release_rst(4, "R5 watchdog reset release");
    wdt_adv_i = 1'b1; wdt_fail_i = 1'b1;
    step(1);
    chk("R5 advanced watchdog shutdown", sd_on(), 1'b1);
    chk("R5 advanced watchdog reset", rst_on(), 1'b1);
    wdt_fail_i = 1'b0;
    release_both(4, "R5 advanced watchdog release");
    wdt_adv_i = 1'b0;
  endtask

  task automatic t_sw();
    wr(8'h16, 8'h04);
    step(4);
    chk("R6 force ignored while locked", sd_on(), 1'b0);
    chk("R6 force ignored reset", rst_on(), 1'b0);
    wr(8'h18, 8'h00);
    step(1);
    chk("R6 force acts when unlocked", sd_on(), 1'b1);
    chk("R6 force drives reset", rst_on(), 1'b1);
    wr(8'h16, 8'h00);
    step(3);
    chk("R6 force cleared hold", sd_on(), 1'b1);
    step(1);
    chk("R6 force cleared release", sd_on(), 1'b0);
    wr(8'h18, 8'h10);
  endtask

  task automatic t_hold();
    wr(8'h10, 8'h01);
    rail1_ov_i = 1'b1;
    step(1);
    rail1_ov_i = 1'b0;
    step(15);
    chk("R7 hold 16 not yet expired", sd_on(), 1'b1);
    rail1_ov_i = 1'b1;   // returns on the expiry edge
    step(1);
    chk("R7 restart on expiry edge shutdown", sd_on(), 1'b1);
    chk("R7 restart on expiry edge reset", rst_on(), 1'b1);
    rail1_ov_i = 1'b0;
    release_both(16, "R7 R10 hold 16 after restart");
    for (int s = 2; s <= 3; s++) begin
      wr(8'h10, 8'(s));
      rail1_uv_i = 1'b1;
      step(1);
      rail1_uv_i = 1'b0;
      step((4 << (2 * s)) - 1);
      chk("R7 long hold still active", sd_on(), 1'b1);
      step(1);
      chk("R7 long hold released", sd_on(), 1'b0);
    end
    wr(8'h10, 8'h00);
  endtask

  task automatic t_rail34();
    rail3_uv_i = 1'b1;
    step(1);
    chk("R8 rail3 reset", rst_on(), 1'b1);
    chk("R8 rail3 no shutdown", sd_on(), 1'b0);
    rail3_uv_i = 1'b0;
    release_rst(4, "R8 rail3 release");
    rail4_uv_i = 1'b1;
    step(1);
    chk("R8 rail4 reset", rst_on(), 1'b1);
    rail4_uv_i = 1'b0;
    release_rst(4, "R8 rail4 release");
  endtask

  task automatic t_mr();
    mr_ni = 1'b0;
    step(2);
    chk("R9 manual reset synchronizer delay", rst_on(), 1'b0);
    step(1);
    chk("R9 manual reset asserted", rst_on(), 1'b1);
    chk("R9 manual reset no shutdown", sd_on(), 1'b0);
    mr_ni = 1'b1;
    release_rst(6, "R9 manual reset release");
  endtask

  task automatic t_pol();
    wr(8'h0D, 8'h02);
    pol = 1'b1;
    chk("R11 active-high idle", sys_rst_o, 1'b0);
    rail3_uv_i = 1'b1;
    step(1);
    chk("R11 active-high asserted", sys_rst_o, 1'b1);
    rail3_uv_i = 1'b0;
    step(4);
    chk("R11 active-high released", sys_rst_o, 1'b0);
    wr(8'h0D, 8'h00);
    pol = 1'b0;
    chk("R11 active-low idle", sys_rst_o, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    t_reset_state();
    t_por();
    t_rail1();
    t_rail2();
    t_wdt();
    t_sw();
    t_hold();
    t_rail34();
    t_mr();
    t_pol();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule